// File: doc/BRIEF.md
# Outbound Message Segmentation Controller

This block takes one outbound message request at a time and splits it into the packet segments that a transmit path will later fill with payload. A request gives the message length in bytes, a 4-bit code that selects the largest payload per segment in double-words (8 bytes), a 6-bit destination mailbox and a 2-bit code for the device-ID width. The block checks the request first. It then either rejects it with a completion code or emits one segment descriptor per packet on a valid/ready output that honours backpressure.

Each descriptor carries:
- the segment index,
- the payload double-word count,
- a last flag,
- the mailbox value to place in the packet,
- the ID-width code,
- the payload-size code.

After the final segment, or right after a rejection, the block raises a one-cycle completion pulse with a 3-bit code. Only then does it take the next request. Moving payload data, building packet headers and driving the link are left to other blocks.

Top module: `msg_seg_ctrl`

## Requirements
- R1: After reset, req_ready is high and seg_valid and cmp_valid are low.
- R2: Payload-size codes 9 to 14 select 1, 2, 4, 8, 16 and 32 double-words per segment. The message holds ceil(length/8) double-words. Every segment except the last carries exactly the selected count, and the last segment carries the remainder (from 1 up to the selected count).
- R3: Segment indexes start at 0 and rise by one. seg_last is high on the final segment only. seg_size_code equals the request's code on every segment.
- R4: If ceil(length/8) exceeds 16 times the selected double-word count, no segment is emitted and the completion code is 101b.
- R5: Payload-size codes 0 to 8 and 15 are reserved. Such a request emits no segment and completes with code 110b.
- R6: ID-width code 00 means 8-bit IDs and 01 means 16-bit IDs, and the code is copied to every segment. Codes 10 and 11 are reserved: no segment is emitted and the completion code is 111b.
- R7: A zero-length request emits no segment and completes with code 001b. When several faults apply, the code is chosen in this order: reserved size code, then reserved ID width, then zero length, then oversize.
- R8: In a message of more than one segment, seg_mbox carries the request's two low mailbox bits with the upper four bits zero. A single-segment message carries all six bits.
- R9: cmp_valid is a one-cycle pulse. Its code is 000b in the cycle after the last segment's handshake. After a rejection, the pulse comes in the cycle after the request was accepted.
- R10: req_ready is high only while the block is idle. It is low from acceptance through the completion pulse.
- R11: While seg_valid is high and seg_ready is low, seg_valid stays high and every descriptor field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_len_bytes | input | LEN_W | Message length in bytes |
| req_size_code | input | 4 | Payload-size code |
| req_mbox | input | 6 | Destination mailbox |
| req_idw | input | 2 | Device-ID width code |
| seg_valid | output | 1 | Segment descriptor valid |
| seg_ready | input | 1 | Consumer takes the descriptor |
| seg_index | output | IDX_W | Segment number within the message |
| seg_dwords | output | 6 | Payload double-words in this segment |
| seg_last | output | 1 | Final segment of the message |
| seg_mbox | output | 6 | Mailbox value for this segment |
| seg_idw | output | 2 | Device-ID width code |
| seg_size_code | output | 4 | Payload-size code of the message |
| cmp_valid | output | 1 | Completion pulse |
| cmp_code | output | 3 | Completion code |

## Verification
The bench targets these corner cases:

- **Exact fit.** A message that fills exactly sixteen full segments must pass, while one byte more must be rejected as oversize. A design that compared with the wrong bound, or counted bytes where it should count double-words, would flip one of these.
- **Lengths that are not whole double-words.** These must round up. A design that truncated would drop the last partial segment or give it a wrong count.
- **Mailbox masking.** The bench checks single-segment and multi-segment messages with all mailbox bits set. A design that masked by request rather than by segment count would send the wrong mailbox.
- **Backpressure.** Stalls mid-message catch a design that advances or changes fields without a handshake.
- **Multiple faults.** Requests that carry several faults at once check the priority of the error codes.

// File: rtl/msg_seg_pkg.sv
package msg_seg_pkg;

  localparam int SIZE_CODE_W = 4;
  localparam int MBOX_W      = 6;
  localparam int IDW_W       = 2;
  localparam int SEG_DW_W    = 6;
  localparam int CC_W        = 3;
  localparam logic [SIZE_CODE_W-1:0] SIZE_CODE_MIN = 4'd9;
  localparam logic [SIZE_CODE_W-1:0] SIZE_CODE_MAX = 4'd14;

  typedef enum logic [CC_W-1:0] {
    CC_OK       = 3'b000,
    CC_ZERO_LEN = 3'b001,
    CC_OVERSIZE = 3'b101,
    CC_BAD_SIZE = 3'b110,
    CC_BAD_IDW  = 3'b111
  } cmpl_code_e;

  function automatic logic size_code_legal(input logic [SIZE_CODE_W-1:0] code);
    return (code >= SIZE_CODE_MIN) && (code <= SIZE_CODE_MAX);
  endfunction

  // Double-words per full segment; meaningful only for legal codes.
  function automatic logic [SEG_DW_W-1:0] seg_dw_of(input logic [SIZE_CODE_W-1:0] code);
    logic [SIZE_CODE_W-1:0] sh;
    sh = code - SIZE_CODE_MIN;
    return SEG_DW_W'(1) << sh;
  endfunction

  function automatic logic idw_legal(input logic [IDW_W-1:0] idw);
    return idw[1] == 1'b0;
  endfunction

endpackage

// File: rtl/msg_seg_req_check.sv
module msg_seg_req_check
  import msg_seg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_SEGS = 16,
  localparam int DW_W    = LEN_W - 2
) (
  input  logic [LEN_W-1:0]       len_bytes,
  input  logic [SIZE_CODE_W-1:0] size_code,
  input  logic [IDW_W-1:0]       idw,
  output cmpl_code_e             code,
  output logic [DW_W-1:0]        total_dw,
  output logic [SEG_DW_W-1:0]    seg_dw,
  output logic                   multi
);

  logic [LEN_W:0] len_round;
  logic [31:0]    limit_dw;

  assign len_round = {1'b0, len_bytes} + (LEN_W+1)'(7);
  assign total_dw  = len_round[LEN_W:3];
  assign seg_dw    = seg_dw_of(size_code);
  assign limit_dw  = 32'(MAX_SEGS) * 32'(seg_dw);
  assign multi     = 32'(total_dw) > 32'(seg_dw);

  always_comb begin
    if (!size_code_legal(size_code))      code = CC_BAD_SIZE;
    else if (!idw_legal(idw))             code = CC_BAD_IDW;
    else if (len_bytes == '0)             code = CC_ZERO_LEN;
    else if (32'(total_dw) > limit_dw)    code = CC_OVERSIZE;
    else                                  code = CC_OK;
  end

endmodule

// File: rtl/msg_seg_sequencer.sv
module msg_seg_sequencer
  import msg_seg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int IDX_W    = 4,
  localparam int DW_W    = LEN_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  cmpl_code_e             start_code,
  input  logic [DW_W-1:0]        start_total_dw,
  input  logic [SEG_DW_W-1:0]    start_seg_dw,
  input  logic [SIZE_CODE_W-1:0] start_size_code,
  input  logic [MBOX_W-1:0]      start_mbox,
  input  logic [IDW_W-1:0]       start_idw,
  input  logic                   seg_ready,
  output logic                   idle,
  output logic                   seg_valid,
  output logic [IDX_W-1:0]       seg_index,
  output logic [SEG_DW_W-1:0]    seg_dwords,
  output logic                   seg_last,
  output logic [MBOX_W-1:0]      seg_mbox,
  output logic [IDW_W-1:0]       seg_idw,
  output logic [SIZE_CODE_W-1:0] seg_size_code,
  output logic                   cmp_valid,
  output logic [CC_W-1:0]        cmp_code
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_CMPL} seq_state_e;

  seq_state_e             state;
  logic [IDX_W-1:0]       idx_q;
  logic [DW_W-1:0]        rem_q;
  logic [SEG_DW_W-1:0]    seg_dw_q;
  logic [MBOX_W-1:0]      mbox_q;
  logic [IDW_W-1:0]       idw_q;
  logic [SIZE_CODE_W-1:0] size_q;
  cmpl_code_e             cc_q;
  logic                   is_last;

  assign is_last = rem_q <= DW_W'(seg_dw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx_q    <= '0;
      rem_q    <= '0;
      seg_dw_q <= '0;
      mbox_q   <= '0;
      idw_q    <= '0;
      size_q   <= '0;
      cc_q     <= CC_OK;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx_q    <= '0;
          rem_q    <= start_total_dw;
          seg_dw_q <= start_seg_dw;
          mbox_q   <= start_mbox;
          idw_q    <= start_idw;
          size_q   <= start_size_code;
          cc_q     <= start_code;
          state    <= (start_code == CC_OK) ? S_SEND : S_CMPL;
        end
        S_SEND: if (seg_ready) begin
          if (is_last) begin
            state <= S_CMPL;
            cc_q  <= CC_OK;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            rem_q <= rem_q - DW_W'(seg_dw_q);
          end
        end
        S_CMPL:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle          = state == S_IDLE;
  assign seg_valid     = state == S_SEND;
  assign cmp_valid     = state == S_CMPL;
  assign cmp_code      = cc_q;
  assign seg_index     = idx_q;
  assign seg_last      = is_last;
  assign seg_dwords    = is_last ? SEG_DW_W'(rem_q) : seg_dw_q;
  assign seg_mbox      = mbox_q;
  assign seg_idw       = idw_q;
  assign seg_size_code = size_q;

endmodule

// File: rtl/msg_seg_ctrl.sv
module msg_seg_ctrl
  import msg_seg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int MAX_SEGS = 16,
  localparam int IDX_W   = $clog2(MAX_SEGS),
  localparam int DW_W    = LEN_W - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [LEN_W-1:0]       req_len_bytes,
  input  logic [SIZE_CODE_W-1:0] req_size_code,
  input  logic [MBOX_W-1:0]      req_mbox,
  input  logic [IDW_W-1:0]       req_idw,
  output logic                   seg_valid,
  input  logic                   seg_ready,
  output logic [IDX_W-1:0]       seg_index,
  output logic [SEG_DW_W-1:0]    seg_dwords,
  output logic                   seg_last,
  output logic [MBOX_W-1:0]      seg_mbox,
  output logic [IDW_W-1:0]       seg_idw,
  output logic [SIZE_CODE_W-1:0] seg_size_code,
  output logic                   cmp_valid,
  output logic [CC_W-1:0]        cmp_code
);

  cmpl_code_e          chk_code;
  logic [DW_W-1:0]     chk_total_dw;
  logic [SEG_DW_W-1:0] chk_seg_dw;
  logic                chk_multi;
  logic [MBOX_W-1:0]   mbox_eff;
  logic                idle;

  // Named events for the checker
  logic req_fire;
  logic seg_fire;
  logic last_fire;

  msg_seg_req_check #(.LEN_W(LEN_W), .MAX_SEGS(MAX_SEGS)) check_i (
    .len_bytes (req_len_bytes),
    .size_code (req_size_code),
    .idw       (req_idw),
    .code      (chk_code),
    .total_dw  (chk_total_dw),
    .seg_dw    (chk_seg_dw),
    .multi     (chk_multi)
  );

  // Multi-segment messages keep only the two low mailbox bits
  assign mbox_eff = chk_multi ? {{(MBOX_W-2){1'b0}}, req_mbox[1:0]} : req_mbox;

  msg_seg_sequencer #(.LEN_W(LEN_W), .IDX_W(IDX_W)) seq_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (req_fire),
    .start_code      (chk_code),
    .start_total_dw  (chk_total_dw),
    .start_seg_dw    (chk_seg_dw),
    .start_size_code (req_size_code),
    .start_mbox      (mbox_eff),
    .start_idw       (req_idw),
    .seg_ready       (seg_ready),
    .idle            (idle),
    .seg_valid       (seg_valid),
    .seg_index       (seg_index),
    .seg_dwords      (seg_dwords),
    .seg_last        (seg_last),
    .seg_mbox        (seg_mbox),
    .seg_idw         (seg_idw),
    .seg_size_code   (seg_size_code),
    .cmp_valid       (cmp_valid),
    .cmp_code        (cmp_code)
  );

  assign req_ready = idle;
  assign req_fire  = req_valid && req_ready;
  assign seg_fire  = seg_valid && seg_ready;
  assign last_fire = seg_fire && seg_last;

endmodule

// File: rtl/msg_seg_ctrl_chk.sv
module msg_seg_ctrl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_fire,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic             seg_fire,
  input logic             last_fire,
  input logic [IDX_W-1:0] seg_index,
  input logic [5:0]       seg_dwords,
  input logic             seg_last,
  input logic [5:0]       seg_mbox,
  input logic [1:0]       seg_idw,
  input logic [3:0]       seg_size_code,
  input logic             cmp_valid,
  input logic [2:0]       cmp_code
);

  AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_size_code >= 4'd9 && seg_size_code <= 4'd14)); // R5

  AST_DW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_dwords != 6'd0 && seg_dwords <= (6'd1 << (seg_size_code - 4'd9)))); // R2

  AST_FULL_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_last) |-> seg_dwords == (6'd1 << (seg_size_code - 4'd9))); // R2

  AST_LEGAL_IDW: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_idw[1] == 1'b0); // R6

  AST_MBOX_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !(seg_last && seg_index == '0)) |-> seg_mbox[5:2] == 4'd0); // R8

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_fire && !seg_last) |=> (seg_valid && seg_index == $past(seg_index) + IDX_W'(1))); // R3

  AST_CMP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> (cmp_valid && cmp_code == 3'b000)); // R9

  AST_CMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !cmp_valid); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid || cmp_valid) |-> !req_ready); // R10

  AST_FIRE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready); // R10

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_index) && $stable(seg_dwords)
      && $stable(seg_last) && $stable(seg_mbox) && $stable(seg_idw) && $stable(seg_size_code))); // R11

endmodule

bind msg_seg_ctrl msg_seg_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .req_fire      (req_fire),
  .seg_valid     (seg_valid),
  .seg_ready     (seg_ready),
  .seg_fire      (seg_fire),
  .last_fire     (last_fire),
  .seg_index     (seg_index),
  .seg_dwords    (seg_dwords),
  .seg_last      (seg_last),
  .seg_mbox      (seg_mbox),
  .seg_idw       (seg_idw),
  .seg_size_code (seg_size_code),
  .cmp_valid     (cmp_valid),
  .cmp_code      (cmp_code)
);

// File: tb/msg_seg_ctrl_tb_top.sv
`timescale 1ns/1ps
module msg_seg_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_len_bytes = '0;
  logic [3:0]  req_size_code = '0;
  logic [5:0]  req_mbox = '0;
  logic [1:0]  req_idw = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [3:0]  seg_index;
  logic [5:0]  seg_dwords;
  logic        seg_last;
  logic [5:0]  seg_mbox;
  logic [1:0]  seg_idw;
  logic [3:0]  seg_size_code;
  logic        cmp_valid;
  logic [2:0]  cmp_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  msg_seg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_len_bytes(req_len_bytes), .req_size_code(req_size_code),
    .req_mbox(req_mbox), .req_idw(req_idw),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_index(seg_index), .seg_dwords(seg_dwords), .seg_last(seg_last),
    .seg_mbox(seg_mbox), .seg_idw(seg_idw), .seg_size_code(seg_size_code),
    .cmp_valid(cmp_valid), .cmp_code(cmp_code)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Issue one request, collect its segments and completion, compare with a model
  task automatic run_msg(input int len, input int sc, input int mb, input int idw, input bit stall);
    int seg_dw, dw, exp_cc, nseg, got, hold_i, hold_d, hold_m;
    bit done, hold_pend, cmp_due;
    string cc_req;
    seg_dw = (sc >= 9 && sc <= 14) ? (1 << (sc - 9)) : 0;
    dw = (len + 7) / 8;
    if (seg_dw == 0)            begin exp_cc = 6; cc_req = "R5"; end
    else if (idw >= 2)          begin exp_cc = 7; cc_req = "R6"; end
    else if (len == 0)          begin exp_cc = 1; cc_req = "R7"; end
    else if (dw > 16 * seg_dw)  begin exp_cc = 5; cc_req = "R4"; end
    else                        begin exp_cc = 0; cc_req = "R9"; end
    nseg = (exp_cc == 0) ? (dw + seg_dw - 1) / seg_dw : 0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_len_bytes = 16'(len); req_size_code = 4'(sc);
    req_mbox = 6'(mb); req_idw = 2'(idw);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; done = 0; hold_pend = 0; cmp_due = 0;
    hold_i = 0; hold_d = 0; hold_m = 0;
    for (int cyc = 0; cyc < 2000 && !done; cyc++) begin
      bit r;
      r = stall ? ((cyc % 3) != 1) : 1'b1;
      seg_ready = r;
      if (hold_pend) begin
        chk(seg_valid && int'(seg_index) == hold_i && int'(seg_dwords) == hold_d
            && int'(seg_mbox) == hold_m, "R11", "hold under backpressure",
            int'(seg_dwords), hold_d);
        hold_pend = 0;
      end
      if (cmp_due) begin
        chk(cmp_valid == 1'b1, "R9", "completion after last", int'(cmp_valid), 1);
        cmp_due = 0;
      end
      if (exp_cc != 0 && cyc == 0)
        chk(cmp_valid == 1'b1, cc_req, "rejection completes at once", int'(cmp_valid), 1);
      if (cmp_valid) begin
        chk(int'(cmp_code) == exp_cc, cc_req, "completion code", int'(cmp_code), exp_cc);
        chk(got == nseg, cc_req, "segment count", got, nseg);
        chk(req_ready == 1'b0, "R10", "not ready during completion", int'(req_ready), 0);
        done = 1;
      end else if (seg_valid) begin
        if (got >= nseg) begin
          chk(1'b0, cc_req, "unexpected segment", got + 1, nseg);
          done = 1;
        end else begin
          int exp_d, exp_m;
          exp_d = (got == nseg - 1) ? dw - got * seg_dw : seg_dw;
          exp_m = (nseg > 1) ? (mb & 3) : mb;
          if (r) begin
            chk(int'(seg_index) == got, "R3", "segment index", int'(seg_index), got);
            chk(int'(seg_dwords) == exp_d, "R2", "segment dwords", int'(seg_dwords), exp_d);
            chk(seg_last == (got == nseg - 1), "R3", "last flag", int'(seg_last), int'(got == nseg - 1));
            chk(int'(seg_size_code) == sc, "R3", "size code kept", int'(seg_size_code), sc);
            chk(int'(seg_mbox) == exp_m, "R8", "mailbox", int'(seg_mbox), exp_m);
            chk(int'(seg_idw) == idw, "R6", "id width", int'(seg_idw), idw);
            chk(req_ready == 1'b0, "R10", "not ready while sending", int'(req_ready), 0);
            if (seg_last) cmp_due = 1;
            got++;
          end else begin
            hold_pend = 1;
            hold_i = int'(seg_index); hold_d = int'(seg_dwords); hold_m = int'(seg_mbox);
          end
        end
      end
      @(negedge clk);
    end
    seg_ready = 1'b0;
    chk(done, cc_req, "completion seen", int'(done), 1);
    chk(cmp_valid == 1'b0, "R9", "completion is one pulse", int'(cmp_valid), 0);
    chk(req_ready == 1'b1, "R10", "ready after completion", int'(req_ready), 1);
  endtask

  task automatic test_reset();
    chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
    chk(seg_valid == 1'b0, "R1", "reset seg_valid", int'(seg_valid), 0);
    chk(cmp_valid == 1'b0, "R1", "reset cmp_valid", int'(cmp_valid), 0);
  endtask

  task automatic test_single();       // R8 full mailbox, R2 one segment
    run_msg(8, 9, 45, 0, 0);
    run_msg(256, 14, 63, 1, 0);
  endtask

  task automatic test_multi_exact();  // R4 boundary: exactly 16 segments
    run_msg(256, 10, 63, 0, 0);
    run_msg(4096, 14, 46, 1, 0);
  endtask

  task automatic test_partial_last(); // R2 rounding and short last segment
    run_msg(100, 11, 22, 0, 0);
    run_msg(9, 9, 7, 1, 0);
  endtask

  task automatic test_backpressure(); // R11
    run_msg(200, 12, 61, 1, 1);
  endtask

  task automatic test_oversize();     // R4
    run_msg(257, 10, 5, 0, 0);
    run_msg(4097, 14, 5, 0, 0);
  endtask

  task automatic test_reserved();     // R5 R6 R7 priority
    run_msg(64, 8, 1, 0, 0);
    run_msg(64, 15, 1, 0, 0);
    run_msg(64, 11, 1, 2, 0);
    run_msg(64, 15, 1, 3, 0);
    run_msg(0, 11, 1, 0, 0);
    run_msg(0, 11, 1, 3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_single();
    test_multi_exact();
    test_partial_last();
    test_backpressure();
    test_oversize();
    test_reserved();
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule